// File: doc/BRIEF.md
# EPROM Fast-Programming Sequencer

This block programs a contiguous range of a byte-wide, UV-erasable EPROM and reports whether the range verified. A host gives a start pulse with first and last addresses. For each address the sequencer asks the host for the byte over a valid/ready handshake. It then drives the byte onto the device data bus and applies fixed-width program pulses on the chip-enable line. After each pulse it reads the byte back. A byte that reads back correctly moves the sequencer to the next address. A byte that does not gets another pulse, up to a fixed limit per byte.

When the last byte of the range has verified, the sequencer lowers both high-voltage supply selects to nominal. It then asks for every byte of the range a second time and reads each one back in normal read mode. One mismatch, in either pass, ends the run with `fail` and the failing address. If there is no mismatch the run ends with `pass`. All waits are counted in clock cycles. Each count is the required time multiplied by the `CLK_HZ` parameter, rounded up to a whole cycle, with a minimum of one cycle.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset the block is idle with `busy`, `pass`, `fail` and `byte_ready` low, `rom_ce_n` and `rom_oe_n` high, `rom_dq_oe` low, and both `vcc_hi` and `vpp_hi` low.
- R2: An accepted start raises `vcc_hi` first. `vpp_hi` follows at least ceil(1 µs) cycles later, and `vpp_hi` is never high while `vcc_hi` is low. When programming ends, `vpp_hi` drops first and `vcc_hi` drops after it. Both are low when the block is idle again.
- R3: Each program pulse holds `rom_ce_n` low for exactly ceil(100 µs × CLK_HZ) cycles. During the pulse `rom_oe_n` is high, `rom_dq_oe` is high and both supply selects are high.
- R4: Before `rom_ce_n` falls for a pulse, the address, the driven data and `vpp_hi` have been unchanged for at least ceil(1 µs) cycles. After `rom_ce_n` rises, the data stays driven for at least ceil(1 µs) cycles.
- R5: After each pulse the bus is released (`rom_dq_oe` low) before `rom_oe_n` falls, and the two are never active together. The byte is read with `rom_ce_n` high and `rom_oe_n` low, and compared with the byte being programmed. A match moves the block to the next address with no further pulse. A mismatch gives another pulse.
- R6: One address receives at most 25 pulses. If the read after the 25th pulse still mismatches, the run ends with `fail` high and `fail_addr` equal to that address. No later address is programmed, and no final read takes place.
- R7: After the last address verifies, both supply selects go low. The block then asks for each byte again, from first to last, and reads it with `rom_ce_n` and `rom_oe_n` low. The first mismatch ends the run with `fail` and `fail_addr` equal to that address.
- R8: `pass` goes high when every byte of the final read pass matches. `pass` and `fail` are never high together, and both hold until the next accepted start.
- R9: `byte_ready` is high only while the block waits for a byte, and the byte is taken in the cycle `byte_valid` is high. While `byte_valid` stays low, `rom_addr` is unchanged and no pulse is given. Each pass asks for one byte per address, in ascending address order.
- R10: A start asserted while `busy` is high is ignored. `first_addr` and `last_addr` are sampled only on an accepted start.
- R11: A range with `first_addr` equal to `last_addr` programs and verifies that single byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a run when idle |
| first_addr | input | ADDR_W | First address of the range |
| last_addr | input | ADDR_W | Last address of the range (not below first_addr) |
| byte_valid | input | 1 | Host presents a byte |
| byte_data | input | DATA_W | Byte for the current address |
| byte_ready | output | 1 | Sequencer waits for a byte |
| busy | output | 1 | A run is in progress |
| pass | output | 1 | Last run verified in full |
| fail | output | 1 | Last run failed |
| fail_addr | output | ADDR_W | Address that failed |
| rom_addr | output | ADDR_W | Device address bus |
| rom_dq_out | output | DATA_W | Data driven to the device |
| rom_dq_in | input | DATA_W | Data read from the device |
| rom_dq_oe | output | 1 | Drive enable for rom_dq_out |
| rom_ce_n | output | 1 | Device chip enable / program pulse, active low |
| rom_oe_n | output | 1 | Device output enable, active low |
| vcc_hi | output | 1 | Select programming-level Vcc (otherwise nominal) |
| vpp_hi | output | 1 | Select programming-level Vpp (otherwise nominal) |

## Verification
The assertions assume that the host keeps `byte_data` stable while `byte_valid` is high and that it lowers `byte_valid` once the byte is taken. They also assume that `last_addr` is not below `first_addr`, and that the device settles its read data within the counted access window. The bench host presents the byte for the address currently on `rom_addr`, in the same half cycle in which it sees `byte_ready`, and drops `byte_valid` one cycle later. Some runs insert several wait cycles before the byte is offered. The device model returns its stored cell combinationally while `rom_oe_n` is low and the bus is released, so the reads stay inside the one-cycle access window. Every range the bench requests keeps last at or above first.

// File: rtl/eps_pkg.sv
package eps_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_VCC_UP,
    ST_VPP_UP,
    ST_FETCH,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_RELEASE,
    ST_PVERIFY,
    ST_VPP_DN,
    ST_VCC_DN,
    ST_FV_FETCH,
    ST_FV_READ
  } eps_state_e;

  // Cycles needed to cover ns nanoseconds at hz, rounded up, never zero.
  function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                                input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 64'd0) c = 64'd1;
    return c[31:0];
  endfunction

  // Device pin levels wanted in a given state: {vcc_hi, vpp_hi, ce_n, oe_n, dq_oe}.
  function automatic logic [4:0] pins_for(input eps_state_e s);
    logic vcc, vpp, ce_n, oe_n, dq_oe;
    vcc   = s inside {ST_VCC_UP, ST_VPP_UP, ST_FETCH, ST_SETUP, ST_PULSE,
                      ST_HOLD, ST_RELEASE, ST_PVERIFY, ST_VPP_DN};
    vpp   = s inside {ST_VPP_UP, ST_FETCH, ST_SETUP, ST_PULSE, ST_HOLD,
                      ST_RELEASE, ST_PVERIFY};
    ce_n  = !(s inside {ST_PULSE, ST_FV_READ});
    oe_n  = !(s inside {ST_PVERIFY, ST_FV_READ});
    dq_oe = s inside {ST_SETUP, ST_PULSE, ST_HOLD};
    return {vcc, vpp, ce_n, oe_n, dq_oe};
  endfunction

endpackage

// File: rtl/eps_delay.sv
module eps_delay #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] limit,
  output logic          done
);
  logic [TW-1:0] cnt_q, cnt_d;

  assign done = (cnt_q == limit - TW'(1));

  always_comb begin
    if (restart)   cnt_d = '0;
    else if (done) cnt_d = cnt_q;
    else           cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  dly_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0) |-> (cnt_q < limit || restart));
endmodule

// File: rtl/eps_addr_ctr.sv
module eps_addr_ctr #(
  parameter int unsigned AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic [AW-1:0] last_val,
  output logic [AW-1:0] addr,
  output logic          at_last
);
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load)      addr_d = load_val;
    else if (step) addr_d = addr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr    = addr_q;
  assign at_last = (addr_q == last_val);

  // R9
  no_step_past_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !at_last);
endmodule

// File: rtl/eps_retry_ctr.sv
module eps_retry_ctr #(
  parameter int unsigned MAXP = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic spent
);
  localparam int unsigned RW = $clog2(MAXP + 1);
  logic [RW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign spent = (cnt_q == RW'(MAXP));

  // R6
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RW'(MAXP));
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eps_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned MAX_PULSE = 25,
  parameter int unsigned PULSE_NS  = 100_000,
  parameter int unsigned SETUP_NS  = 1_000,
  parameter int unsigned HOLD_NS   = 1_000,
  parameter int unsigned VACC_NS   = 100,
  parameter int unsigned RACC_NS   = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  output logic              byte_ready,
  output logic              busy,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [DATA_W-1:0] rom_dq_out,
  input  logic [DATA_W-1:0] rom_dq_in,
  output logic              rom_dq_oe,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              vcc_hi,
  output logic              vpp_hi
);
  localparam int unsigned PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_HZ);
  localparam int unsigned SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_HZ);
  localparam int unsigned HOLD_CYC  = ns_to_cycles(HOLD_NS, CLK_HZ);
  localparam int unsigned VACC_CYC  = ns_to_cycles(VACC_NS, CLK_HZ);
  localparam int unsigned RACC_CYC  = ns_to_cycles(RACC_NS, CLK_HZ);
  localparam int unsigned M1 = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int unsigned M2 = (HOLD_CYC > VACC_CYC) ? HOLD_CYC : VACC_CYC;
  localparam int unsigned M3 = (M1 > M2) ? M1 : M2;
  localparam int unsigned MAX_CYC = (M3 > RACC_CYC) ? M3 : RACC_CYC;
  localparam int unsigned TW = $clog2(MAX_CYC + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  eps_state_e        state_q, state_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [ADDR_W-1:0] first_q, first_d, last_q, last_d, fail_addr_q, fail_addr_d;
  logic              pass_q, pass_d, fail_q, fail_d, pend_q, pend_d;
  logic [4:0]        pins_q, pins_d;

  logic [TW-1:0]     dly_limit;
  logic              dly_restart, dly_done;
  logic              addr_load, addr_step, addr_at_last;
  logic [ADDR_W-1:0] addr_cur;
  logic              rtry_clr, rtry_inc, rtry_spent;
  logic              rd_match;

  assign rd_match = (rom_dq_in == data_q);

  eps_delay #(.TW(TW)) u_delay (
    .clk(clk), .rst_n(rst_int_n), .restart(dly_restart),
    .limit(dly_limit), .done(dly_done)
  );

  eps_addr_ctr #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_int_n), .load(addr_load), .load_val(first_q),
    .step(addr_step), .last_val(last_q), .addr(addr_cur), .at_last(addr_at_last)
  );

  eps_retry_ctr #(.MAXP(MAX_PULSE)) u_retry (
    .clk(clk), .rst_n(rst_int_n), .clr(rtry_clr), .inc(rtry_inc), .spent(rtry_spent)
  );

  // wait length for the state being timed
  always_comb begin
    unique case (state_q)
      ST_VCC_UP, ST_VPP_UP, ST_SETUP,
      ST_VPP_DN, ST_VCC_DN:  dly_limit = TW'(SETUP_CYC);
      ST_PULSE:              dly_limit = TW'(PULSE_CYC);
      ST_HOLD:               dly_limit = TW'(HOLD_CYC);
      ST_PVERIFY:            dly_limit = TW'(VACC_CYC);
      ST_FV_READ:            dly_limit = TW'(RACC_CYC);
      default:               dly_limit = TW'(1);
    endcase
  end

  // next-state logic
  always_comb begin
    state_d     = state_q;
    data_d      = data_q;
    first_d     = first_q;
    last_d      = last_q;
    fail_addr_d = fail_addr_q;
    pass_d      = pass_q;
    fail_d      = fail_q;
    pend_d      = pend_q;
    addr_step   = 1'b0;
    rtry_clr    = 1'b0;
    rtry_inc    = 1'b0;
    addr_load   = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          first_d = first_addr;
          last_d  = last_addr;
          pass_d  = 1'b0;
          fail_d  = 1'b0;
          pend_d  = 1'b0;
          state_d = ST_VCC_UP;
        end
      end
      ST_VCC_UP: begin
        addr_load = 1'b1;
        if (dly_done) state_d = ST_VPP_UP;
      end
      ST_VPP_UP:  if (dly_done) state_d = ST_FETCH;
      ST_FETCH: begin
        if (byte_valid) begin
          data_d   = byte_data;
          rtry_clr = 1'b1;
          state_d  = ST_SETUP;
        end
      end
      ST_SETUP:   if (dly_done) state_d = ST_PULSE;
      ST_PULSE: begin
        if (dly_done) begin
          rtry_inc = 1'b1;
          state_d  = ST_HOLD;
        end
      end
      ST_HOLD:    if (dly_done) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_PVERIFY;
      ST_PVERIFY: begin
        if (dly_done) begin
          if (rd_match) begin
            if (addr_at_last) begin
              state_d = ST_VPP_DN;
            end else begin
              addr_step = 1'b1;
              state_d   = ST_FETCH;
            end
          end else if (rtry_spent) begin
            pend_d      = 1'b1;
            fail_addr_d = addr_cur;
            state_d     = ST_VPP_DN;
          end else begin
            state_d = ST_SETUP;
          end
        end
      end
      ST_VPP_DN:  if (dly_done) state_d = ST_VCC_DN;
      ST_VCC_DN: begin
        if (dly_done) begin
          if (pend_q) begin
            fail_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            addr_load = 1'b1;
            state_d   = ST_FV_FETCH;
          end
        end
      end
      ST_FV_FETCH: begin
        if (byte_valid) begin
          data_d  = byte_data;
          state_d = ST_FV_READ;
        end
      end
      ST_FV_READ: begin
        if (dly_done) begin
          if (!rd_match) begin
            fail_d      = 1'b1;
            fail_addr_d = addr_cur;
            state_d     = ST_IDLE;
          end else if (addr_at_last) begin
            pass_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            addr_step = 1'b1;
            state_d   = ST_FV_FETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    pins_d = pins_for(state_d);
  end

  assign dly_restart = (state_d != state_q);

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q     <= ST_IDLE;
      data_q      <= '0;
      first_q     <= '0;
      last_q      <= '0;
      fail_addr_q <= '0;
      pass_q      <= 1'b0;
      fail_q      <= 1'b0;
      pend_q      <= 1'b0;
      pins_q      <= pins_for(ST_IDLE);
    end else begin
      state_q     <= state_d;
      data_q      <= data_d;
      first_q     <= first_d;
      last_q      <= last_d;
      fail_addr_q <= fail_addr_d;
      pass_q      <= pass_d;
      fail_q      <= fail_d;
      pend_q      <= pend_d;
      pins_q      <= pins_d;
    end
  end

  assign {vcc_hi, vpp_hi, rom_ce_n, rom_oe_n, rom_dq_oe} = pins_q;
  assign rom_addr   = addr_cur;
  assign rom_dq_out = data_q;
  assign byte_ready = (state_q == ST_FETCH) || (state_q == ST_FV_FETCH);
  assign busy       = (state_q != ST_IDLE);
  assign pass       = pass_q;
  assign fail       = fail_q;
  assign fail_addr  = fail_addr_q;

  // R2
  vpp_needs_vcc_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    vpp_hi |-> vcc_hi);

  // R5
  bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rom_oe_n |-> !rom_dq_oe);

  // R3
  pulse_pins_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!rom_ce_n && vpp_hi) |-> (rom_dq_oe && rom_oe_n));

  // R8
  pass_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(pass && fail));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (byte_ready && !byte_valid) |=> ($stable(rom_addr) && rom_ce_n));

  // R10
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && start) |=> $stable(last_q));
endmodule

// File: tb/tb_eprom_prog_seq.sv
module tb_eprom_prog_seq;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 64;
  localparam int PULSE_CYC = 100;
  localparam int SETUP_CYC = 1;
  localparam int HOLD_CYC = 1;
  localparam int MAXP = 25;
  localparam int BAD = 20;
  localparam int WEAK = 33;
  localparam int RUN_LIMIT = 40000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] first_addr = '0, last_addr = '0;
  logic byte_valid = 1'b0;
  logic [DW-1:0] byte_data = '0;
  logic byte_ready, busy, pass, fail;
  logic [AW-1:0] fail_addr, rom_addr;
  logic [DW-1:0] rom_dq_out, rom_dq_in;
  logic rom_dq_oe, rom_ce_n, rom_oe_n, vcc_hi, vpp_hi;

  always #10 clk = ~clk;

  eprom_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_HZ(1_000_000), .MAX_PULSE(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr),
    .last_addr(last_addr), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .busy(busy), .pass(pass), .fail(fail),
    .fail_addr(fail_addr), .rom_addr(rom_addr), .rom_dq_out(rom_dq_out),
    .rom_dq_in(rom_dq_in), .rom_dq_oe(rom_dq_oe), .rom_ce_n(rom_ce_n),
    .rom_oe_n(rom_oe_n), .vcc_hi(vcc_hi), .vpp_hi(vpp_hi)
  );

  function automatic logic [7:0] data_of(input int a);
    return 8'((a * 37 + 5) & 8'h7F);
  endfunction
  function automatic int need_of(input int a);
    return (a == BAD) ? 1000 : (a % 3) + 1;
  endfunction

  // device model and pin monitors
  logic [7:0] mem [DEPTH];
  int pulses [DEPTH];
  logic erase_req = 1'b0;
  bit stall_en = 1'b0;
  int reqs, fv_reads;
  int v_order, v_clash, v_pw, v_ppins, v_setup, v_hold, v_fv, v_stall;
  logic prev_ce_n = 1'b1, prev_dq_oe = 1'b0, in_pulse = 1'b0;
  logic [DW-1:0] prev_dq;
  logic [AW-1:0] prev_addr;
  int low_len, since_rise, st_dq, st_addr, st_vpp, wait_ctr;
  logic after_pulse = 1'b0;

  assign rom_dq_in = (!rom_oe_n && !rom_dq_oe)
                   ? (mem[rom_addr] ^ ((!vcc_hi && int'(rom_addr) == WEAK) ? 8'h01 : 8'h00))
                   : 8'hEE;

  initial begin
    v_order = 0; v_clash = 0; v_pw = 0; v_ppins = 0; v_setup = 0; v_hold = 0;
    v_fv = 0; v_stall = 0; fv_reads = 0; low_len = 0; since_rise = 0;
    st_dq = 0; st_addr = 0; st_vpp = 0;
  end

  always @(negedge clk) begin
    if (erase_req) begin
      for (int i = 0; i < DEPTH; i++) begin mem[i] = 8'hFF; pulses[i] = 0; end
      fv_reads = 0;
    end else if (rst_n) begin
      if (vpp_hi && !vcc_hi) v_order++;
      if (rom_dq_oe && !rom_oe_n) v_clash++;
      if (prev_ce_n && !rom_ce_n) begin
        if (vpp_hi) begin
          in_pulse = 1'b1; low_len = 0;
          if (st_dq < SETUP_CYC || st_addr < SETUP_CYC || st_vpp < SETUP_CYC) v_setup++;
        end else if (!rom_oe_n) begin
          fv_reads++;
          if (vcc_hi) v_fv++;
        end
      end
      if (in_pulse && !rom_ce_n) begin
        low_len++;
        if (!rom_dq_oe || !rom_oe_n || !vpp_hi || !vcc_hi) v_ppins++;
      end
      if (in_pulse && rom_ce_n) begin
        in_pulse = 1'b0;
        if (low_len != PULSE_CYC) v_pw++;
        pulses[rom_addr]++;
        if (pulses[rom_addr] >= need_of(int'(rom_addr))) mem[rom_addr] &= prev_dq;
        after_pulse = 1'b1; since_rise = rom_dq_oe ? 1 : 0;
      end else if (after_pulse) begin
        if (rom_dq_oe) since_rise++;
      end
      if (after_pulse && prev_dq_oe && !rom_dq_oe) begin
        if (since_rise < HOLD_CYC) v_hold++;
        after_pulse = 1'b0;
      end
      st_dq   = (rom_dq_oe && rom_dq_out == prev_dq) ? st_dq + 1 : (rom_dq_oe ? 1 : 0);
      st_addr = (rom_addr == prev_addr) ? st_addr + 1 : 1;
      st_vpp  = vpp_hi ? st_vpp + 1 : 0;
      prev_ce_n = rom_ce_n; prev_dq_oe = rom_dq_oe; prev_dq = rom_dq_out; prev_addr = rom_addr;
    end
  end

  // host side of the byte handshake
  always @(negedge clk) begin
    if (erase_req) begin
      reqs = 0; wait_ctr = 0; byte_valid <= 1'b0;
    end else if (byte_ready && !byte_valid) begin
      if (!rom_ce_n) v_stall++;
      if (stall_en && wait_ctr < 6) begin
        wait_ctr++;
      end else begin
        byte_valid <= 1'b1; byte_data <= data_of(int'(rom_addr)); reqs++; wait_ctr = 0;
      end
    end else begin
      byte_valid <= 1'b0;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int f, input int l, input bit stall, input bit poke, input string tag);
    int cyc, fail_at, exp_reqs, exp_fv, exp_p;
    bit bad_hit, weak_hit;
    @(negedge clk) erase_req = 1'b1;
    @(negedge clk) erase_req = 1'b0;
    stall_en = stall; first_addr = AW'(f); last_addr = AW'(l);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 300) begin start = 1'b1; first_addr = AW'(50); last_addr = AW'(50); end
      if (poke && cyc == 301) begin start = 1'b0; first_addr = AW'(f); last_addr = AW'(l); end
    end while (busy && cyc < RUN_LIMIT);
    chk(cyc < RUN_LIMIT, {tag, " watchdog"}, cyc, RUN_LIMIT);

    bad_hit = (f <= BAD && BAD <= l);
    weak_hit = !bad_hit && (f <= WEAK && WEAK <= l);
    fail_at = bad_hit ? BAD : (weak_hit ? WEAK : -1);
    exp_reqs = bad_hit ? (BAD - f + 1) : (weak_hit ? (l - f + 1) + (WEAK - f + 1) : 2 * (l - f + 1));
    exp_fv = bad_hit ? 0 : (weak_hit ? WEAK - f + 1 : l - f + 1);

    chk(pass == (fail_at < 0), {tag, " R8 pass"}, int'(pass), int'(fail_at < 0));
    chk(fail == (fail_at >= 0), {tag, bad_hit ? " R6 fail" : " R7 fail"}, int'(fail), int'(fail_at >= 0));
    if (fail_at >= 0)
      chk(int'(fail_addr) == fail_at, {tag, bad_hit ? " R6 fail_addr" : " R7 fail_addr"}, int'(fail_addr), fail_at);
    chk(reqs == exp_reqs, {tag, " R9 byte requests"}, reqs, exp_reqs);
    chk(fv_reads == exp_fv, {tag, " R7 final reads"}, fv_reads, exp_fv);
    for (int a = f; a <= l; a++) begin
      exp_p = (bad_hit && a > BAD) ? 0 : ((a == BAD) ? MAXP : need_of(a));
      chk(pulses[a] == exp_p, {tag, (a == BAD) ? " R6 pulses" : " R5 pulses"}, pulses[a], exp_p);
      chk(mem[a] == ((exp_p >= need_of(a)) ? data_of(a) : 8'hFF), {tag, " R5 cell"},
          int'(mem[a]), int'((exp_p >= need_of(a)) ? data_of(a) : 8'hFF));
    end
    chk(!vcc_hi && !vpp_hi && rom_ce_n && rom_oe_n && !rom_dq_oe, {tag, " R2 idle pins"},
        int'({vcc_hi, vpp_hi, rom_ce_n, rom_oe_n, rom_dq_oe}), 5'b00110);
    chk(v_order == 0, {tag, " R2 supply order"}, v_order, 0);
    chk(v_pw == 0 && v_ppins == 0, {tag, " R3 pulse"}, v_pw + v_ppins, 0);
    chk(v_setup == 0 && v_hold == 0, {tag, " R4 setup/hold"}, v_setup + v_hold, 0);
    chk(v_clash == 0, {tag, " R5 bus release"}, v_clash, 0);
    chk(v_fv == 0, {tag, " R7 nominal supply"}, v_fv, 0);
    chk(v_stall == 0, {tag, " R9 stall"}, v_stall, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(!busy && !pass && !fail && !byte_ready, "R1 status", int'({busy, pass, fail, byte_ready}), 0);
    chk(rom_ce_n && rom_oe_n && !rom_dq_oe && !vcc_hi && !vpp_hi, "R1 pins",
        int'({vcc_hi, vpp_hi, rom_ce_n, rom_oe_n, rom_dq_oe}), 5'b00110);

    run(0, 11, 1'b0, 1'b1, "R10 run busy start");
    run(12, 17, 1'b1, 1'b0, "stall run");
    run(18, 23, 1'b0, 1'b0, "retry limit run");
    run(30, 35, 1'b1, 1'b0, "final verify run");
    run(40, 40, 1'b0, 1'b0, "R11 single run");
    run(0, 19, 1'b0, 1'b0, "low range run");
    run(41, 63, 1'b1, 1'b0, "top range run");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule